// File: doc/BRIEF.md
# Multi-Mode DMA Channel Engine

This block is one DMA channel that moves data across a simple single-master bus, where every access takes one clock. Software programs a source address, a destination address, a transfer count, a unit size, an address mode for each side and a set of options. It then pulses a load strobe. From that point the channel runs through its transfers on its own. When the count runs out it stops and raises a sticky completion flag.

A transfer can use one of two paths. The dual path spends a read cycle at the source and then a write cycle at the destination. The single path spends one cycle and raises an acknowledge strobe, which selects the peripheral on the other side. The 16-byte unit reads four 32-bit words into a small internal buffer and then writes them out. Options let the channel wait for an external request level before each transfer, and rewind the source address to its programmed start after every fourth transfer.

Top module: `dma_chan_engine`

## Requirements
- R1: While reset is held and afterwards, until the first load, `bus_req`, `bus_ack`, `active` and `done` are all 0.
- R2: Suppose `cfg_we` is sampled high at a clock edge. In the following cycle `active` is 1 and no access is made (an arming cycle). Every transfer is preceded by exactly one arming cycle when it is not waiting for a request. The transfer's accesses then follow back to back.
- R3: In dual mode (`cfg_single`=0), a transfer first reads at the source address with `bus_we`=0. It then writes at the destination address with `bus_we`=1. The written data is the read data masked to the unit width: bits [7:0] for 8-bit units, bits [15:0] for 16-bit units, all 32 bits otherwise.
- R4: `cfg_size` encodes 0 as 8-bit, 1 as 16-bit, 2 as 32-bit and 3 as 16-byte. `bus_size` shows the access width (0, 1 or 2). An incrementing address steps by 1, 2, 4 or 16 bytes per transfer.
- R5: A 16-byte unit makes four reads with `bus_size`=2 at source+0, +4, +8 and +12. It then makes four writes at destination+0, +4, +8 and +12, carrying the four read words in the same order.
- R6: Each side's mode takes the value 1 to increment, 2 to decrement, and 0 or 3 to stay fixed. Both addresses are updated after each transfer.
- R7: In single mode a transfer is one access with `bus_ack`=1. When `cfg_dir`=0, it reads (`bus_we`=0) at the source address. When `cfg_dir`=1, it writes (`bus_we`=1) at the destination address with `bus_wdata`=0.
- R8: With `cfg_reload`=1, the source address returns to its programmed start after every fourth transfer. The destination address keeps advancing.
- R9: With `cfg_ext_en`=1, a transfer starts in the cycle after an arming cycle in which `ext_req` is sampled high. The channel stays in arming cycles while `ext_req` is low. With `cfg_ext_en`=0, `ext_req` has no effect.
- R10: After the final access of the last transfer, `active` is 0 and `done` is 1 in the next cycle. `done` then holds until `done_clr` is sampled high, and reads 0 in the cycle after that.
- R11: A programmed count of 0 means 16777216 transfers, so the channel is still active after several transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the configuration and start the channel |
| cfg_src | input | 32 | Source start address |
| cfg_dst | input | 32 | Destination start address |
| cfg_cnt | input | 24 | Transfer count (0 means 2^24) |
| cfg_size | input | 2 | Unit size code |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_single | input | 1 | Select single-address mode |
| cfg_dir | input | 1 | Single mode: 0 reads memory, 1 writes memory |
| cfg_ext_en | input | 1 | Wait for the external request before each transfer |
| cfg_reload | input | 1 | Rewind the source after every fourth transfer |
| done_clr | input | 1 | Clear the completion flag |
| ext_req | input | 1 | External transfer request level |
| bus_rdata | input | 32 | Read data, valid in the access cycle |
| bus_req | output | 1 | Access in this cycle |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Access address |
| bus_size | output | 2 | Access width code |
| bus_wdata | output | 32 | Write data |
| bus_ack | output | 1 | Peripheral acknowledge strobe (single mode) |
| active | output | 1 | Channel enabled |
| done | output | 1 | Sticky completion flag |

## Verification
All bus outputs come from registers. An access therefore appears in the cycle after the edge that decided it. The first arming cycle falls one cycle after the load edge, and `done` falls one cycle after the last access. The bench's reference model turns each programmed job into a list of expected per-cycle states: arming cycles, accesses, and the completion cycles that follow. It pops one entry at every falling edge, where it also drives the `ext_req` level the entry calls for. It compares the outputs there, half a cycle clear of the edge that produced them.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int LINE_BEATS = 4;
  localparam int BEAT_W     = $clog2(LINE_BEATS);
  localparam int RELOAD_PER = 4;
  localparam int GRP_W      = $clog2(RELOAD_PER);

  typedef enum logic [1:0] {
    UNIT_B8   = 2'd0,
    UNIT_B16  = 2'd1,
    UNIT_B32  = 2'd2,
    UNIT_LINE = 2'd3
  } unit_e;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_HOLD  = 2'd3
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_RD   = 3'd2,
    ST_WR   = 3'd3,
    ST_SGL  = 3'd4
  } st_e;
endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side
  import dma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [AW-1:0]       load_addr,
  input  logic [1:0]          load_mode,
  input  unit_e               unit,
  input  logic                step,
  input  logic                rewind,
  input  logic [BEAT_W-1:0]   beat,
  output logic [AW-1:0]       addr
);
  logic [AW-1:0] base_q, base_d, start_q, stride;
  amode_e        mode_q;

  always_comb begin
    case (unit)
      UNIT_B8:  stride = AW'(1);
      UNIT_B16: stride = AW'(2);
      UNIT_B32: stride = AW'(4);
      default:  stride = AW'(4 * LINE_BEATS);
    endcase
  end

  always_comb begin
    base_d = base_q;
    if (load)                          base_d = load_addr;
    else if (rewind)                   base_d = start_q;
    else if (step && mode_q == AM_INC) base_d = base_q + stride;
    else if (step && mode_q == AM_DEC) base_d = base_q - stride;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      mode_q  <= AM_FIXED;
    end else if (load) begin
      start_q <= load_addr;
      mode_q  <= amode_e'(load_mode);
    end
  end

  assign addr = (unit == UNIT_LINE) ? base_q + AW'({beat, 2'b00}) : base_q;

  // R8
  rewind_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && !load) |=> (base_q == start_q));

  // R6
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !rewind && !load && mode_q == AM_INC) |=> (base_q == $past(base_q) + $past(stride)));
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
  import dma_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_cnt,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_single,
  input  logic              cfg_dir,
  input  logic              cfg_ext_en,
  input  logic              cfg_reload,
  input  logic              ext_req,
  input  logic              done_clr,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_ack,
  output logic              latch_en,
  output logic              xfer_end,
  output logic              src_rewind,
  output logic              active,
  output logic              done,
  output logic [BEAT_W-1:0] beat,
  output unit_e             unit
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_BEATS - 1);
  localparam logic [GRP_W-1:0]  LAST_GRP  = GRP_W'(RELOAD_PER - 1);

  st_e               st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [GRP_W-1:0]  grp_q, grp_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              done_q, done_d;
  unit_e             unit_q;
  logic              single_q, dir_q, ext_q, rld_q;
  logic              last_beat;

  assign last_beat = (unit_q != UNIT_LINE) || (beat_q == LAST_BEAT);
  assign xfer_end  = (st_q == ST_WR && last_beat) || (st_q == ST_SGL);

  always_comb begin
    st_d   = st_q;
    beat_d = beat_q;
    grp_d  = grp_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    case (st_q)
      ST_ARM: if (!ext_q || ext_req) st_d = single_q ? ST_SGL : ST_RD;
      ST_RD: begin
        if (last_beat) begin
          st_d   = ST_WR;
          beat_d = '0;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      ST_WR:   if (!last_beat) beat_d = beat_q + 1'b1;
      default: ;
    endcase
    if (done_clr) done_d = 1'b0;
    if (xfer_end) begin
      cnt_d  = cnt_q - 1'b1;
      beat_d = '0;
      grp_d  = grp_q + 1'b1;
      if (cnt_q == CW'(1)) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end else begin
        st_d = ST_ARM;
      end
    end
    if (cfg_we) begin
      st_d   = ST_ARM;
      cnt_d  = cfg_cnt;
      beat_d = '0;
      grp_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      grp_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      grp_q  <= grp_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_q   <= UNIT_B8;
      single_q <= 1'b0;
      dir_q    <= 1'b0;
      ext_q    <= 1'b0;
      rld_q    <= 1'b0;
    end else if (cfg_we) begin
      unit_q   <= unit_e'(cfg_size);
      single_q <= cfg_single;
      dir_q    <= cfg_dir;
      ext_q    <= cfg_ext_en;
      rld_q    <= cfg_reload;
    end
  end

  assign bus_req    = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_SGL);
  assign bus_we     = (st_q == ST_WR) || (st_q == ST_SGL && dir_q);
  assign bus_ack    = (st_q == ST_SGL);
  assign latch_en   = (st_q == ST_RD);
  assign src_rewind = xfer_end && rld_q && (grp_q == LAST_GRP);
  assign active     = (st_q != ST_IDLE);
  assign done       = done_q;
  assign beat       = beat_q;
  assign unit       = unit_q;

  // R1
  req_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> active);

  // R7
  ack_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (bus_req && single_q));

  // R9
  wait_for_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARM && ext_q && !ext_req && !cfg_we) |=> !bus_req);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);

  // R11
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !cfg_we) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [1:0]    cfg_size,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic          cfg_single,
  input  logic          cfg_dir,
  input  logic          cfg_ext_en,
  input  logic          cfg_reload,
  input  logic          done_clr,
  input  logic          ext_req,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_ack,
  output logic          active,
  output logic          done
);
  logic              latch_en, xfer_end, src_rewind;
  logic [BEAT_W-1:0] beat;
  unit_e             unit;
  logic [AW-1:0]     src_addr, dst_addr;
  logic [DW-1:0]     word_q [LINE_BEATS];
  logic [DW-1:0]     lane_mask;

  dma_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cnt(cfg_cnt),
    .cfg_size(cfg_size), .cfg_single(cfg_single), .cfg_dir(cfg_dir),
    .cfg_ext_en(cfg_ext_en), .cfg_reload(cfg_reload), .ext_req(ext_req),
    .done_clr(done_clr), .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack),
    .latch_en(latch_en), .xfer_end(xfer_end), .src_rewind(src_rewind),
    .active(active), .done(done), .beat(beat), .unit(unit)
  );

  dma_addr_side #(.AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n), .load(cfg_we), .load_addr(cfg_src),
    .load_mode(cfg_src_mode), .unit(unit), .step(xfer_end),
    .rewind(src_rewind), .beat(beat), .addr(src_addr)
  );

  dma_addr_side #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(cfg_we), .load_addr(cfg_dst),
    .load_mode(cfg_dst_mode), .unit(unit), .step(xfer_end),
    .rewind(1'b0), .beat(beat), .addr(dst_addr)
  );

  for (genvar g = 0; g < LINE_BEATS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  word_q[g] <= '0;
      else if (latch_en && beat == BEAT_W'(g))     word_q[g] <= bus_rdata;
    end
  end

  always_comb begin
    case (unit)
      UNIT_B8:  lane_mask = DW'(8'hFF);
      UNIT_B16: lane_mask = DW'(16'hFFFF);
      default:  lane_mask = '1;
    endcase
  end

  assign bus_addr  = (bus_we && !bus_ack) || (bus_ack && bus_we) ? dst_addr : src_addr;
  assign bus_size  = (unit == UNIT_LINE) ? 2'd2 : unit;
  assign bus_wdata = (bus_we && !bus_ack) ? (word_q[beat] & lane_mask) : '0;

  // R3
  dual_write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_ack && unit != UNIT_LINE) |-> ($past(bus_req) && !$past(bus_we)));
endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [23:0] cfg_cnt = '0;
  logic [1:0]  cfg_size = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
  logic        cfg_single = 1'b0, cfg_dir = 1'b0, cfg_ext_en = 1'b0, cfg_reload = 1'b0;
  logic        done_clr = 1'b0, ext_req = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_req, bus_we, bus_ack, active, done;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [31:0] mem(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3C3, ~a[15:0]};
  endfunction

  assign bus_rdata = mem(bus_addr);

  dma_chan_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_cnt(cfg_cnt), .cfg_size(cfg_size), .cfg_src_mode(cfg_src_mode),
    .cfg_dst_mode(cfg_dst_mode), .cfg_single(cfg_single), .cfg_dir(cfg_dir),
    .cfg_ext_en(cfg_ext_en), .cfg_reload(cfg_reload), .done_clr(done_clr),
    .ext_req(ext_req), .bus_rdata(bus_rdata), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .active(active), .done(done)
  );

  typedef struct {
    bit        req, we, ack, act, dn, ext;
    bit [31:0] addr, wd;
    bit [1:0]  sz;
    string     tag;
  } ent_t;

  ent_t q[$];

  function automatic ent_t idle_e(bit act, bit dn, bit ext, string tag);
    ent_t e;
    e.req = 0; e.we = 0; e.ack = 0; e.act = act; e.dn = dn; e.ext = ext;
    e.addr = 0; e.wd = 0; e.sz = 0; e.tag = tag;
    return e;
  endfunction

  function automatic ent_t acc_e(bit we, bit ack, bit [31:0] a, bit [1:0] sz,
                                 bit [31:0] wd, string tag);
    ent_t e;
    e.req = 1; e.we = we; e.ack = ack; e.act = 1; e.dn = 0; e.ext = 0;
    e.addr = a; e.wd = wd; e.sz = sz; e.tag = tag;
    return e;
  endfunction

  function automatic bit [31:0] adv(bit [31:0] a, bit [1:0] m, int b);
    if (m == 2'd1) return a + b;
    if (m == 2'd2) return a - b;
    return a;
  endfunction

  // Reference model: expected per-cycle trace of one programmed job.
  task automatic build(bit [31:0] s0, bit [31:0] d0, int nx, bit fin, bit [1:0] sz,
                       bit [1:0] sm, bit [1:0] dm, bit sgl, bit dir, bit rld,
                       int waits, string tag);
    bit [31:0] s = s0, d = d0, msk;
    int bytes;
    bytes = (sz == 3) ? 16 : (1 << sz);
    msk = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    q.delete();
    for (int k = 1; k <= nx; k++) begin
      for (int w = 0; w <= waits; w++) q.push_back(idle_e(1, 0, (waits > 0) && (w == waits), tag));
      if (sgl) begin
        if (dir) q.push_back(acc_e(1, 1, d, sz, 0, tag));
        else     q.push_back(acc_e(0, 1, s, sz, 0, tag));
      end else if (sz == 3) begin
        for (int b = 0; b < 4; b++) q.push_back(acc_e(0, 0, s + 4*b, 2, 0, tag));
        for (int b = 0; b < 4; b++) q.push_back(acc_e(1, 0, d + 4*b, 2, mem(s + 4*b), tag));
      end else begin
        q.push_back(acc_e(0, 0, s, sz, 0, tag));
        q.push_back(acc_e(1, 0, d, sz, mem(s) & msk, tag));
      end
      s = (rld && (k % 4 == 0)) ? s0 : adv(s, sm, bytes);
      d = adv(d, dm, bytes);
    end
    if (fin) begin
      q.push_back(idle_e(0, 1, 0, "R10"));
      q.push_back(idle_e(0, 1, 0, "R10"));
    end
  endtask

  task automatic check_e(ent_t e);
    bit ok;
    ok = (bus_req == e.req) && (active == e.act) && (done == e.dn) && (bus_ack == e.ack);
    if (e.req) ok = ok && (bus_we == e.we) && (bus_addr == e.addr) &&
                    (bus_size == e.sz) && (bus_wdata == e.wd);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got req=%0b we=%0b ack=%0b addr=%h sz=%0d wd=%h act=%0b dn=%0b exp req=%0b we=%0b ack=%0b addr=%h sz=%0d wd=%h act=%0b dn=%0b",
               e.tag, bus_req, bus_we, bus_ack, bus_addr, bus_size, bus_wdata, active, done,
               e.req, e.we, e.ack, e.addr, e.sz, e.wd, e.act, e.dn);
    end
  endtask

  task automatic run(bit [31:0] s0, bit [31:0] d0, bit [23:0] cnt, int nx, bit [1:0] sz,
                     bit [1:0] sm, bit [1:0] dm, bit sgl, bit dir, bit ext, bit rld,
                     int waits, string tag);
    build(s0, d0, nx, cnt != 0, sz, sm, dm, sgl, dir, rld, waits, tag);
    @(negedge clk);
    cfg_src = s0; cfg_dst = d0; cfg_cnt = cnt; cfg_size = sz; cfg_src_mode = sm;
    cfg_dst_mode = dm; cfg_single = sgl; cfg_dir = dir; cfg_ext_en = ext; cfg_reload = rld;
    cfg_we = 1; done_clr = 1;
    @(negedge clk);
    cfg_we = 0; done_clr = 0;
    while (q.size() > 0) begin
      ent_t e;
      e = q.pop_front();
      ext_req = e.ext;
      check_e(e);
      @(negedge clk);
    end
    ext_req = 0;
  endtask

  task automatic check_bit(bit act, bit exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b exp %0b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset and just after release
    check_bit(bus_req | bus_ack | active | done, 1'b0, "R1");
    rst_n = 1;
    @(negedge clk);
    check_bit(bus_req | bus_ack | active | done, 1'b0, "R1");

    // R2 R3 R4: dual 32-bit, both incrementing
    run(32'h0000_1000, 32'h0000_8000, 24'd3, 3, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0, 0, "R3");
    // R4 R6: 8-bit, source decrements, destination fixed
    run(32'h0000_2010, 32'h0000_9000, 24'd3, 3, 2'd0, 2'd2, 2'd0, 0, 0, 0, 0, 0, "R6");
    // R4: 16-bit steps, mode code 3 held fixed on the destination
    run(32'h0000_3000, 32'h0000_A002, 24'd2, 2, 2'd1, 2'd1, 2'd3, 0, 0, 0, 0, 0, "R4");
    // R5: 16-byte units, source up, destination down
    run(32'h0000_4000, 32'h0000_B100, 24'd2, 2, 2'd3, 2'd1, 2'd2, 0, 0, 0, 0, 0, "R5");
    // R7: single-address read and write
    run(32'h0000_5000, 32'h0000_C000, 24'd2, 2, 2'd2, 2'd1, 2'd0, 1, 0, 0, 0, 0, "R7");
    run(32'h0000_5000, 32'h0000_C000, 24'd2, 2, 2'd1, 2'd0, 2'd1, 1, 1, 0, 0, 0, "R7");
    // R8: source rewinds every fourth transfer
    run(32'h0000_6000, 32'h0000_D000, 24'd9, 9, 2'd2, 2'd1, 2'd1, 0, 0, 0, 1, 0, "R8");
    // R9: wait three arming cycles for the request before each transfer
    run(32'h0000_7000, 32'h0000_E000, 24'd2, 2, 2'd2, 2'd1, 2'd1, 0, 0, 1, 0, 3, "R9");

    // R10: done holds until cleared
    repeat (4) @(negedge clk);
    check_bit(done, 1'b1, "R10");
    check_bit(active, 1'b0, "R10");
    done_clr = 1;
    @(negedge clk);
    done_clr = 0;
    check_bit(done, 1'b0, "R10");

    // R11: count 0 keeps running past several transfers
    run(32'h0000_1100, 32'h0000_2200, 24'd0, 6, 2'd2, 2'd1, 2'd1, 0, 0, 0, 0, 0, "R11");
    check_bit(active, 1'b1, "R11");
    check_bit(done, 1'b0, "R11");
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_bit(active | done, 1'b0, "R1");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule